// File: doc/BRIEF.md
# Tamper event controller with erasable backup store

This block gathers single-cycle detection pulses from three external tamper channels and four internal tamper sources. Every source that is enabled keeps a sticky status flag. External channels also have a mask control and a no-erase control. A masked channel sends out only a trigger pulse. An unmasked channel sets its flag and signals an event. A channel whose no-erase bit is clear, and every internal source, also wipes the backup store.

The backup store holds 32 words of 32 bits. After an erasing tamper it stays at zero until software has cleared every status flag. A separate erase-request input clears the store at any time. Software reaches the block through a plain word-wide register port with write enable, address and write data, and a combinational read-data output. An external domain-protect input must be high for any write to take effect.

Top module: `tamper_guard`

## Requirements
- R1: After reset every register reads zero, including all backup words. The outputs trig_o, evt_o, erase_o and irq_o are low.
- R2: A pulse on an enabled, unmasked source sets its status flag on that clock edge. evt_o is high for exactly the following cycle.
- R3: A pulse on a disabled source has no effect. While a source's flag is set, further pulses on that source are ignored and the flag stays set.
- R4: Writing 1 to a bit of the clear register (offset 0x14) clears the matching flag. If a clear and a new pulse on the same source fall in the same cycle, the pulse wins: the flag stays set and evt_o pulses.
- R5: A masked external channel never shows a set flag and does not pulse evt_o. Mask bits sit at bits 8 to 10 of the policy register (offset 0x04).
- R6: trig_o[i] is high for one cycle after each accepted pulse on external channel i, whether the channel is masked or not.
- R7: An erasing tamper clears all backup words and pulses erase_o one cycle later. An erasing tamper is an unmasked external channel whose no-erase bit (policy bits 0 to 2) is 0, or any enabled internal source.
- R8: After an erasing tamper, backup words read zero and ignore writes until all flags are clear. After that, writes take effect again.
- R9: A tamper on a channel that is masked or has no-erase set leaves the backup words untouched.
- R10: The masked status register (offset 0x10) reads status AND interrupt enable (offset 0x08). irq_o is high when any masked status bit is set.
- R11: While wr_en_dom_i is low, every register write is ignored, and this includes the backup words and the clear register.
- R12: A pulse on erase_req_i clears all backup words.
- R13: External sources use bits 0 to 2 and internal sources use bits 18 to 21 of the enable (0x00), interrupt enable, status, masked status and clear registers. Other bits read zero. The clear register always reads zero. Backup word k lives at 0x100 + 4k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_evt_i | input | 3 | Detection pulses, external channels |
| int_evt_i | input | 4 | Detection pulses, internal sources |
| wr_en_dom_i | input | 1 | Domain write permission; writes ignored when low |
| erase_req_i | input | 1 | Clear request for the backup store |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 9 | Byte address of the register word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| trig_o | output | 3 | Per-channel trigger pulse |
| evt_o | output | 1 | Pulse when any flag is newly set |
| erase_o | output | 1 | Pulse after an erasing tamper |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two things can land on the same edge: a software write-1-to-clear of a flag and a fresh detection pulse on that same source. The bench sets the flag first. It then drives the clear write and the pulse in one cycle, and expects the flag to read back set with evt_o pulsing. A clear with no pulse must then empty the flag. A second overlap is a backup write during an erase hold. The write must be lost and the word must read zero until the flags are cleared.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  localparam int N_EXT    = 3;
  localparam int N_INT    = 4;
  localparam int N_SRC    = N_EXT + N_INT;
  localparam int INT_LSB  = 18;
  localparam int MASK_LSB = 8;
  localparam int AW       = 9;
  localparam int WW       = 32;

  localparam logic [AW-1:0] OFS_EN    = 9'h000;
  localparam logic [AW-1:0] OFS_POL   = 9'h004;
  localparam logic [AW-1:0] OFS_IE    = 9'h008;
  localparam logic [AW-1:0] OFS_STAT  = 9'h00C;
  localparam logic [AW-1:0] OFS_MSTAT = 9'h010;
  localparam logic [AW-1:0] OFS_CLR   = 9'h014;
  localparam logic [AW-1:0] BKP_BASE  = 9'h100;

  function automatic logic [WW-1:0] src_to_word(input logic [N_SRC-1:0] v);
    logic [WW-1:0] w;
    w = '0;
    for (int i = 0; i < N_EXT; i++) w[i] = v[i];
    for (int i = 0; i < N_INT; i++) w[INT_LSB+i] = v[N_EXT+i];
    return w;
  endfunction

  function automatic logic [N_SRC-1:0] word_to_src(input logic [WW-1:0] w);
    logic [N_SRC-1:0] v;
    for (int i = 0; i < N_EXT; i++) v[i] = w[i];
    for (int i = 0; i < N_INT; i++) v[N_EXT+i] = w[INT_LSB+i];
    return v;
  endfunction
endpackage

// File: rtl/tamper_chan.sv
module tamper_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic en_i,
  input  logic msk_i,
  input  logic clr_i,
  output logic hit_o,
  output logic flag_nxt_o,
  output logic flag_o
);
  logic flag_q;

  // a clear in the same cycle reopens the channel, so the new pulse wins
  assign hit_o      = evt_i & en_i & (~flag_q | clr_i);
  assign flag_nxt_o = (hit_o & ~msk_i) | (flag_q & ~clr_i & ~msk_i);
  assign flag_o     = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_nxt_o;
  end
endmodule

// File: rtl/tamper_bkp_bank.sv
module tamper_bkp_bank #(
  parameter int N  = 32,
  parameter int DW = 32,
  parameter int IW = $clog2(N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            we_i,
  input  logic [IW-1:0]   idx_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [N*DW-1:0] words_o
);
  for (genvar w = 0; w < N; w++) begin : g_word
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        q <= '0;
      else if (clear_i)                   q <= '0;
      else if (we_i && idx_i == IW'(w))   q <= wdata_i;
    end
    assign words_o[w*DW +: DW] = q;
  end
endmodule

// File: rtl/tamper_guard.sv
module tamper_guard
  import tamper_pkg::*;
#(
  parameter int N_BKP = 32,
  parameter int DW    = WW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EXT-1:0] ext_evt_i,
  input  logic [N_INT-1:0] int_evt_i,
  input  logic             wr_en_dom_i,
  input  logic             erase_req_i,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic [N_EXT-1:0] trig_o,
  output logic             evt_o,
  output logic             erase_o,
  output logic             irq_o
);
  localparam int IW = $clog2(N_BKP);
  localparam logic [AW:0] BKP_SPAN = (AW+1)'(4*N_BKP);

  logic [N_SRC-1:0] en_q, ie_q, flag_q, flag_nxt;
  logic [N_SRC-1:0] hit_src, set_src, ers_src, clr_src, msk_src, noer_src, evt_src;
  logic [N_EXT-1:0] mask_q, noer_q, trig_q;
  logic             evt_q, erase_q, hold_q, ers_now, wr;
  logic [AW-1:0]    bkp_off;
  logic             in_bkp;
  logic [IW-1:0]    bkp_idx;
  logic [N_BKP*DW-1:0] bkp_flat;

  assign wr = reg_we_i & wr_en_dom_i;

  always_comb begin
    bkp_off = reg_addr_i - BKP_BASE;
    in_bkp  = (reg_addr_i >= BKP_BASE) && (bkp_off[1:0] == 2'b00) && ({1'b0, bkp_off} < BKP_SPAN);
    bkp_idx = bkp_off[IW+1:2];
  end

  assign clr_src  = (wr && reg_addr_i == OFS_CLR) ? word_to_src(reg_wdata_i[WW-1:0]) : '0;
  assign msk_src  = {{N_INT{1'b0}}, mask_q};
  assign noer_src = {{N_INT{1'b0}}, noer_q};
  assign evt_src  = {int_evt_i, ext_evt_i};

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    tamper_chan u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt_src[s]),
      .en_i      (en_q[s]),
      .msk_i     (msk_src[s]),
      .clr_i     (clr_src[s]),
      .hit_o     (hit_src[s]),
      .flag_nxt_o(flag_nxt[s]),
      .flag_o    (flag_q[s])
    );
  end

  assign set_src = hit_src & ~msk_src;
  assign ers_src = set_src & ~noer_src;
  assign ers_now = |ers_src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      ie_q   <= '0;
      mask_q <= '0;
      noer_q <= '0;
    end else if (wr) begin
      unique case (reg_addr_i)
        OFS_EN:  en_q <= word_to_src(reg_wdata_i[WW-1:0]);
        OFS_IE:  ie_q <= word_to_src(reg_wdata_i[WW-1:0]);
        OFS_POL: begin
          noer_q <= reg_wdata_i[N_EXT-1:0];
          mask_q <= reg_wdata_i[MASK_LSB +: N_EXT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q  <= '0;
      evt_q   <= 1'b0;
      erase_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      trig_q  <= hit_src[N_EXT-1:0];
      evt_q   <= |set_src;
      erase_q <= ers_now;
      if (ers_now)          hold_q <= 1'b1;
      else if (~|flag_nxt)  hold_q <= 1'b0;
    end
  end

  tamper_bkp_bank #(.N(N_BKP), .DW(DW), .IW(IW)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(ers_now | hold_q | erase_req_i),
    .we_i   (wr & in_bkp),
    .idx_i  (bkp_idx),
    .wdata_i(reg_wdata_i),
    .words_o(bkp_flat)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFS_EN:    reg_rdata_o[WW-1:0] = src_to_word(en_q);
      OFS_IE:    reg_rdata_o[WW-1:0] = src_to_word(ie_q);
      OFS_STAT:  reg_rdata_o[WW-1:0] = src_to_word(flag_q);
      OFS_MSTAT: reg_rdata_o[WW-1:0] = src_to_word(flag_q & ie_q);
      OFS_POL: begin
        reg_rdata_o[N_EXT-1:0]           = noer_q;
        reg_rdata_o[MASK_LSB +: N_EXT]   = mask_q;
      end
      default: if (in_bkp) reg_rdata_o = bkp_flat[bkp_idx*DW +: DW];
    endcase
  end

  assign trig_o  = trig_q;
  assign evt_o   = evt_q;
  assign erase_o = erase_q;
  assign irq_o   = |(flag_q & ie_q);
endmodule

// File: rtl/tamper_guard_chk.sv
module tamper_guard_chk
  import tamper_pkg::*;
#(
  parameter int N_BKP = 32,
  parameter int DW    = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_dom_i,
  input logic              erase_req_i,
  input logic              irq_o,
  input logic              evt_o,
  input logic              erase_o,
  input logic [N_SRC-1:0]  flag_q,
  input logic [N_SRC-1:0]  clr_src,
  input logic [N_SRC-1:0]  msk_src,
  input logic [N_SRC-1:0]  ie_q,
  input logic              hold_q,
  input logic [N_BKP*DW-1:0] bkp_flat
);
  assert_flag_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> &(flag_q | ~$past(flag_q & ~clr_src & ~msk_src)));

  assert_masked_no_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_q & $past(msk_src)) == '0));

  assert_evt_has_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> (flag_q != '0));

  assert_irq_has_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_q != '0));

  assert_erase_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_o |-> (bkp_flat == '0));

  assert_hold_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q |-> (bkp_flat == '0));

  assert_wp_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_dom_i |=> $stable(ie_q));

  assert_erase_req_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_i |=> (bkp_flat == '0));
endmodule

bind tamper_guard tamper_guard_chk #(.N_BKP(N_BKP), .DW(DW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_dom_i(wr_en_dom_i),
  .erase_req_i(erase_req_i),
  .irq_o      (irq_o),
  .evt_o      (evt_o),
  .erase_o    (erase_o),
  .flag_q     (flag_q),
  .clr_src    (clr_src),
  .msk_src    (msk_src),
  .ie_q       (ie_q),
  .hold_q     (hold_q),
  .bkp_flat   (bkp_flat)
);

// File: tb/test_tamper_guard.sv
module test_tamper_guard;
  localparam logic [8:0] A_EN = 9'h000, A_POL = 9'h004, A_IE = 9'h008;
  localparam logic [8:0] A_STAT = 9'h00C, A_MSTAT = 9'h010, A_CLR = 9'h014, A_BKP = 9'h100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] ext_evt = '0;
  logic [3:0] int_evt = '0;
  logic wr_dom = 1'b1, erase_req = 1'b0, we = 1'b0;
  logic [8:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [2:0] trig;
  logic evt, erase, irq;
  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  tamper_guard i_tamper_guard (
    .clk_i(clk), .rst_ni(rst_n), .ext_evt_i(ext_evt), .int_evt_i(int_evt),
    .wr_en_dom_i(wr_dom), .erase_req_i(erase_req), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .trig_o(trig), .evt_o(evt), .erase_o(erase), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse(input logic [2:0] e, input logic [3:0] i,
                       output logic [2:0] t, output logic ev, output logic er);
    @(negedge clk); ext_evt = e; int_evt = i;
    @(posedge clk); #1 t = trig; ev = evt; er = erase; ext_evt = '0; int_evt = '0;
  endtask

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [2:0] t;
    logic ev, er;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(A_EN, d);   chk("R1 enable", d, 0);
    rd(A_STAT, d); chk("R1 status", d, 0);
    rd(A_BKP + 9'd124, d); chk("R1 backup", d, 0);
    chk("R1 outputs", {26'b0, trig, evt, erase, irq}, 0);

    // R13 bit positions and reserved bits
    wr(A_EN, 32'hFFFF_FFFF); rd(A_EN, d); chk("R13 enable mask", d, 32'h003C_0007);
    wr(A_POL, 32'hFFFF_FFFF); rd(A_POL, d); chk("R13 policy mask", d, 32'h0000_0707);
    wr(A_CLR, 32'hFFFF_FFFF); rd(A_CLR, d); chk("R13 clear reads 0", d, 0);
    wr(A_EN, 0); wr(A_POL, 0);

    // sweep: channel x {mask, noerase}
    for (int ch = 0; ch < 3; ch++) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        logic m, n;
        logic [8:0] ba;
        logic [31:0] pat;
        m = cfg[1]; n = cfg[0];
        ba = A_BKP + 9'(4 * (ch * 4 + cfg));
        pat = 32'hA500_0000 | (ch << 8) | cfg;
        wr(A_POL, (32'(m) << (8 + ch)) | (32'(n) << ch));
        wr(A_EN, 32'(1) << ch);
        wr(ba, pat);
        pulse(3'(1 << ch), 4'h0, t, ev, er);
        chk("R6 trigger", 32'(t), 32'(1 << ch));
        chk("R2 event pulse", 32'(ev), 32'(!m));
        chk("R7 erase pulse", 32'(er), 32'(!m && !n));
        @(posedge clk); #1 chk("R2 event one cycle", 32'(evt), 0);
        rd(A_STAT, d); chk("R5 status", d, 32'(!m) << ch);
        rd(ba, d); chk("R9 backup kept or R7 erased", d, (!m && !n) ? 32'h0 : pat);
        if (!m) begin
          pulse(3'(1 << ch), 4'h0, t, ev, er);
          chk("R3 ignored while set", {28'b0, t, ev}, 0);
          rd(A_STAT, d); chk("R3 flag kept", d, 32'(1) << ch);
        end
        wr(A_CLR, 32'(1) << ch);
        rd(A_STAT, d); chk("R4 cleared", d, 0);
        wr(ba, ~pat); rd(ba, d); chk("R8 writable after release", d, ~pat);
        wr(A_EN, 0); wr(A_POL, 0);
      end
    end

    // R3 disabled sources
    pulse(3'b111, 4'hF, t, ev, er);
    chk("R3 disabled", {27'b0, t, ev, er}, 0);
    rd(A_STAT, d); chk("R3 disabled status", d, 0);

    // internal sources: always erase, hold until clear
    for (int s = 0; s < 4; s++) begin
      wr(A_EN, 32'(1) << (18 + s));
      wr(A_BKP + 9'd20, 32'h5A5A_0000 + s);
      pulse(3'b000, 4'(1 << s), t, ev, er);
      chk("R7 internal", {28'b0, t, er}, 32'h1);
      chk("R2 internal event", 32'(ev), 1);
      rd(A_STAT, d); chk("R13 internal status bit", d, 32'(1) << (18 + s));
      rd(A_BKP + 9'd20, d); chk("R7 internal erased", d, 0);
      wr(A_BKP + 9'd20, 32'h1234); rd(A_BKP + 9'd20, d); chk("R8 hold blocks write", d, 0);
      wr(A_CLR, 32'(1) << (18 + s));
      rd(A_STAT, d); chk("R4 internal cleared", d, 0);
      wr(A_BKP + 9'd20, 32'h1234); rd(A_BKP + 9'd20, d); chk("R8 released", d, 32'h1234);
    end
    wr(A_EN, 0);

    // R4 clear and event in the same cycle
    wr(A_POL, 32'h7); wr(A_EN, 32'h1);
    pulse(3'b001, 4'h0, t, ev, er);
    @(negedge clk); we = 1'b1; addr = A_CLR; wdata = 32'h1; ext_evt = 3'b001;
    @(posedge clk); #1 chk("R4 collision event", 32'(evt), 1);
    we = 1'b0; ext_evt = '0;
    rd(A_STAT, d); chk("R4 collision flag kept", d, 32'h1);
    wr(A_CLR, 32'h1); rd(A_STAT, d); chk("R4 plain clear", d, 0);

    // R10 masked status and interrupt sweep
    wr(A_EN, 32'h7);
    pulse(3'b111, 4'h0, t, ev, er);
    for (int ie = 0; ie < 8; ie++) begin
      wr(A_IE, 32'(ie));
      rd(A_MSTAT, d); chk("R10 masked status", d, 32'(ie));
      chk("R10 irq", 32'(irq), 32'(ie != 0));
    end
    wr(A_CLR, 32'h7); #1 chk("R10 irq after clear", 32'(irq), 0);
    wr(A_IE, 0);

    // R11 write protection
    wr(A_BKP, 32'hCAFE_0001);
    pulse(3'b001, 4'h0, t, ev, er);
    wr_dom = 1'b0;
    wr(A_IE, 32'h7); wr(A_BKP, 32'hBEEF_0002); wr(A_CLR, 32'h1);
    rd(A_IE, d);   chk("R11 ie blocked", d, 0);
    rd(A_BKP, d);  chk("R11 backup blocked", d, 32'hCAFE_0001);
    rd(A_STAT, d); chk("R11 clear blocked", d, 32'h1);
    wr_dom = 1'b1;
    wr(A_CLR, 32'h1); wr(A_EN, 0);

    // R12 erase request
    @(negedge clk); erase_req = 1'b1;
    @(posedge clk); #1 erase_req = 1'b0;
    rd(A_BKP, d); chk("R12 erase request", d, 0);
    rd(A_BKP + 9'd20, d); chk("R12 erase request word 5", d, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule